// File: doc/BRIEF.md
# Pointer-Addressed Eighteen-Port Digital I/O Controller

This block puts eighteen 8-bit bidirectional ports behind a small host register window. The host never addresses a port directly. It first loads a port-select pointer, then reads or writes one shared data register. The data register reaches whichever port the pointer names. Three direction registers each cover six ports. A single global enable gates every port access and every output driver. On the pin side each port has eight output bits, one output enable shared by its eight pins, and eight input bits.

The host side is a plain synchronous register bus. The host presents an address, a write strobe with write data, and a read strobe. Read data is registered. Every transfer completes in one cycle with no back-pressure, so the bus carries no valid/ready pair. The pin side is also plain: levels only, with no handshake. Port p sits on bits [8p+7:8p] of the pin vectors. For a part wired to six connectors of three ports each, connector c, sub-port k (A=0, B=1, C=2) is port 3c+k.

Top module: `ptr_port_io`

## Requirements
- R1: After reset the enable is 0, the port pointer is 0, every port is an input (all direction bits 0), every pin_oe bit is 0 and bus_rdata is 0x00. Output latch contents are undefined until first written.
- R2: Register offsets are as follows. 0x00 is control, with bit 0 as the global enable; bits 7:1 read 0. 0xC4 is the port pointer and reads back all 8 bits. 0xC0 is data. 0xC8, 0xCC and 0xD0 are direction registers for ports 0–5, 6–11 and 12–17. In a direction register, bit n sets port 6g+n, with 1 = output. Bits 7:6 of a direction register read 0.
- R3: A data write while enabled, with pointer ≤ 17, loads the latch of the pointed port. The latch appears on that port's pin_out slice one cycle later. All other latches keep their values.
- R4: pin_oe[p] is 1 exactly when the enable is 1 and direction bit p is 1.
- R5: While disabled, data writes change no latch, data reads return 0x00, and no pin_oe bit is set.
- R6: A data read returns the latch of the pointed port when that port is an output. It returns that port's pin_in value, sampled at the read edge, when the port is an input.
- R7: A data write to an input port updates its latch while pin_oe stays 0. The written value is read back once the port is switched to output.
- R8: With a pointer above 17, data writes change no latch and data reads return 0x00.
- R9: Reads of any offset other than 0x00, 0xC0, 0xC4, 0xC8, 0xCC and 0xD0 return 0x00. Writes to such offsets change no register or latch.
- R10: bus_rdata updates on the clock edge that samples bus_rd, and holds when bus_rd is low. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_out | output | 144 | Output latch values, port p at bits 8p+7:8p |
| pin_oe | output | 18 | Per-port output enable |
| pin_in | input | 144 | External input values, port p at bits 8p+7:8p |

## Verification
The embedded assertions check, on every cycle, that no port drives while the enable is low. They also check that out-of-range pointers neither load a latch nor return data, that reserved and disabled reads return zero, that the top bits of direction reads are zero, and that read data holds between reads. Only the bench scenarios can show that the pointer steers each access to the right one of eighteen latches. They also show that input ports return live pin values while output ports return their latch, and that a value written to an input port survives until the port is turned to output. The bench's cycle model compares pin_out, pin_oe and bus_rdata every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [DATA_W-1:0] OFF_DATA = 8'hC0;
  localparam logic [DATA_W-1:0] OFF_SEL  = 8'hC4;
  localparam logic [DATA_W-1:0] OFF_DIR0 = 8'hC8;
  localparam int DIR_STEP = 4;

  // offset of the direction register for port group g
  function automatic logic [DATA_W-1:0] dir_off(input int g);
    return DATA_W'(int'(OFF_DIR0) + DIR_STEP * g);
  endfunction
endpackage

// File: rtl/pio_ctrl_regs.sv
module pio_ctrl_regs
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 18,
  parameter int GROUP     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    addr,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 en,
  output logic [DATA_W-1:0]    sel,
  output logic [NUM_PORTS-1:0] dir,
  output logic                 data_wr
);
  localparam int NGRP = (NUM_PORTS + GROUP - 1) / GROUP;
  localparam logic [DATA_W-1:0] SEL_LIM = DATA_W'(NUM_PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      sel <= '0;
    end else if (wr) begin
      if (addr == OFF_CTRL) en  <= wdata[0];
      if (addr == OFF_SEL)  sel <= wdata;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_dir
    localparam int LO  = g * GROUP;
    localparam int CNT = (NUM_PORTS - LO < GROUP) ? NUM_PORTS - LO : GROUP;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         dir[LO +: CNT] <= '0;
      else if (wr && addr == dir_off(g))  dir[LO +: CNT] <= wdata[CNT-1:0];
    end
  end

  assign data_wr = wr && (addr == OFF_DATA) && en && (sel < SEL_LIM);
endmodule

// File: rtl/pio_port_latches.sv
module pio_port_latches
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        data_wr,
  input  logic [DATA_W-1:0]           sel,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        en,
  input  logic [NUM_PORTS-1:0]        dir,
  output logic [NUM_PORTS*DATA_W-1:0] pin_out,
  output logic [NUM_PORTS-1:0]        pin_oe
);
  localparam logic [DATA_W-1:0] SEL_LIM = DATA_W'(NUM_PORTS);

  // latches carry no reset: their power-up value is undefined
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (data_wr && sel == DATA_W'(p)) q <= wdata;
    end
    assign pin_out[p*DATA_W +: DATA_W] = q;
  end

  assign pin_oe = {NUM_PORTS{en}} & dir;

  // R8: an out-of-range pointer never loads any latch
  a_r8_oob_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SEL_LIM) |=> $stable(pin_out));
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 18,
  parameter int GROUP     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           addr,
  input  logic                        rd,
  input  logic                        en,
  input  logic [DATA_W-1:0]           sel,
  input  logic [NUM_PORTS-1:0]        dir,
  input  logic [NUM_PORTS*DATA_W-1:0] latch_q,
  input  logic [NUM_PORTS*DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0]           rdata
);
  localparam int NGRP = (NUM_PORTS + GROUP - 1) / GROUP;
  localparam logic [DATA_W-1:0] SEL_LIM = DATA_W'(NUM_PORTS);

  logic [DATA_W-1:0] nxt;
  logic              mapped;

  always_comb begin
    nxt    = '0;
    mapped = (addr == OFF_CTRL) || (addr == OFF_SEL) || (addr == OFF_DATA);
    if (addr == OFF_CTRL) begin
      nxt[0] = en;
    end else if (addr == OFF_SEL) begin
      nxt = sel;
    end else if (addr == OFF_DATA) begin
      if (en) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (sel == DATA_W'(p))
            nxt = dir[p] ? latch_q[p*DATA_W +: DATA_W] : pin_in[p*DATA_W +: DATA_W];
        end
      end
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        if (addr == dir_off(g)) begin
          mapped = 1'b1;
          for (int n = 0; n < GROUP; n++) begin
            if (g * GROUP + n < NUM_PORTS) nxt[n] = dir[g*GROUP + n];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= nxt;
  end

  // R10: read data holds between reads
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  // R8: out-of-range pointer reads zero
  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFF_DATA && sel >= SEL_LIM) |=> (rdata == '0));
  // R5: disabled data read is zero
  a_r5_off_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFF_DATA && !en) |=> (rdata == '0));
  // R9: reserved offsets read zero
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |=> (rdata == '0));
  // R2: unused top bits of a direction read are zero
  a_r2_dir_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == dir_off(0)) |=> (rdata[DATA_W-1:GROUP] == '0));
endmodule

// File: rtl/ptr_port_io.sv
module ptr_port_io
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 18,
  parameter int GROUP     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  bus_addr,
  input  logic                        bus_wr,
  input  logic [7:0]                  bus_wdata,
  input  logic                        bus_rd,
  output logic [7:0]                  bus_rdata,
  output logic [NUM_PORTS*8-1:0]      pin_out,
  output logic [NUM_PORTS-1:0]        pin_oe,
  input  logic [NUM_PORTS*8-1:0]      pin_in
);
  logic                 en;
  logic [DATA_W-1:0]    sel;
  logic [NUM_PORTS-1:0] dir;
  logic                 data_wr;

  pio_ctrl_regs #(.NUM_PORTS(NUM_PORTS), .GROUP(GROUP)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .en(en), .sel(sel), .dir(dir), .data_wr(data_wr)
  );

  pio_port_latches #(.NUM_PORTS(NUM_PORTS)) u_latch (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .sel(sel), .wdata(bus_wdata),
    .en(en), .dir(dir), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  pio_read_mux #(.NUM_PORTS(NUM_PORTS), .GROUP(GROUP)) u_rmux (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .en(en), .sel(sel),
    .dir(dir), .latch_q(pin_out), .pin_in(pin_in), .rdata(bus_rdata)
  );

  // R4 / R5: no port drives while the global enable is low
  a_r4_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pin_oe == '0));
  // R1: directions come out of reset as inputs
  a_r1_reset_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/tb_ptr_port_io.sv
module tb_ptr_port_io;
  localparam int NP = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_rdata;
  logic [NP*8-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP*8-1:0] pin_in = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptr_port_io dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  // ---------------- behavioural reference model ----------------
  bit       m_en;
  int       m_sel;
  bit       m_dir [NP];
  int       m_lat [NP];
  bit       m_known [NP];
  int       m_rdata;

  function automatic int model_read(int a);
    if (a == 'h00) return m_en ? 1 : 0;
    if (a == 'hC4) return m_sel;
    if (a == 'hC0) begin
      if (!m_en || m_sel >= NP) return 0;
      if (m_dir[m_sel]) return m_lat[m_sel];
      return int'(pin_in[m_sel*8 +: 8]);
    end
    for (int g = 0; g < 3; g++) begin
      if (a == 'hC8 + 4*g) begin
        int v = 0;
        for (int n = 0; n < 6; n++) if (m_dir[g*6+n]) v |= (1 << n);
        return v;
      end
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_rdata = 0;
      for (int p = 0; p < NP; p++) begin m_dir[p] = 0; m_known[p] = 0; end
    end else begin
      if (bus_rd) m_rdata = model_read(int'(bus_addr));
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_en = bus_wdata[0];
        else if (bus_addr == 8'hC4) m_sel = int'(bus_wdata);
        else if (bus_addr == 8'hC0) begin
          if (m_en && m_sel < NP) begin
            m_lat[m_sel] = int'(bus_wdata); m_known[m_sel] = 1;
          end
        end else begin
          for (int g = 0; g < 3; g++)
            if (int'(bus_addr) == 'hC8 + 4*g)
              for (int n = 0; n < 6; n++) m_dir[g*6+n] = bus_wdata[n];
        end
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (pin_oe[p] !== (m_en & m_dir[p])) begin
          errors++;
          $display("FAIL R4 pin_oe[%0d] got %b exp %b", p, pin_oe[p], m_en & m_dir[p]);
        end
        if (m_known[p]) begin
          checks++;
          if (int'(pin_out[p*8 +: 8]) != m_lat[p]) begin
            errors++;
            $display("FAIL R3 pin_out port %0d got %02h exp %02h", p, pin_out[p*8 +: 8], m_lat[p]);
          end
        end
      end
      checks++;
      if (int'(bus_rdata) != m_rdata) begin
        errors++;
        $display("FAIL R10 bus_rdata got %02h exp %02h", bus_rdata, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %02h got %02h exp %02h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic oe_check(input logic [NP-1:0] exp, input string tag);
    checks++;
    if (pin_oe !== exp) begin
      errors++;
      $display("FAIL %s pin_oe got %05h exp %05h", tag, pin_oe, exp);
    end
  endtask

  // watchdog: a hang counts as a failed check
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired got %0d cycles exp completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    oe_check('0, "R1");
    rd_check(8'h00, 8'h00, "R1");
    rd_check(8'hC4, 8'h00, "R1");
    rd_check(8'hC8, 8'h00, "R1");
    rd_check(8'hD0, 8'h00, "R1");

    // R2: register readback, masked bits
    wr(8'h00, 8'hFF);
    rd_check(8'h00, 8'h01, "R2");
    wr(8'hC4, 8'h0B);
    rd_check(8'hC4, 8'h0B, "R2");
    wr(8'hCC, 8'hFF);
    rd_check(8'hCC, 8'h3F, "R2");
    oe_check(18'h00FC0, "R4");
    wr(8'hCC, 8'h00);

    // R5: writes while disabled are dropped
    wr(8'hC4, 8'h00);
    wr(8'hC0, 8'h11);
    wr(8'h00, 8'h00);
    wr(8'hC0, 8'h22);
    wr(8'hC8, 8'h01);
    oe_check('0, "R5");
    rd_check(8'hC0, 8'h00, "R5");
    wr(8'h00, 8'h01);
    rd_check(8'hC0, 8'h11, "R5");

    // R3/R6: every port written, all outputs, read back
    for (int p = 0; p < NP; p++) begin
      wr(8'hC4, 8'(p));
      wr(8'hC0, 8'(p*7 + 3));
    end
    wr(8'hC8, 8'h3F); wr(8'hCC, 8'h3F); wr(8'hD0, 8'h3F);
    oe_check({NP{1'b1}}, "R4");
    for (int p = 0; p < NP; p++) begin
      wr(8'hC4, 8'(p));
      rd_check(8'hC0, 8'(p*7 + 3), "R6");
    end

    // R6: input port returns pins
    for (int p = 0; p < NP; p++) pin_in[p*8 +: 8] = 8'(8'hA0 ^ (p*13));
    wr(8'hCC, 8'h00);
    wr(8'hC4, 8'd8);
    rd_check(8'hC0, 8'(8'hA0 ^ (8*13)), "R6");
    pin_in[8*8 +: 8] = 8'h5C;
    rd_check(8'hC0, 8'h5C, "R6");

    // R7: write to input port lands in latch only
    wr(8'hC0, 8'hC3);
    oe_check(18'h3F03F, "R7");
    rd_check(8'hC0, 8'h5C, "R7");
    wr(8'hCC, 8'h04);
    rd_check(8'hC0, 8'hC3, "R7");

    // R8: out-of-range pointer
    wr(8'hC4, 8'd18);
    wr(8'hC0, 8'hFF);
    rd_check(8'hC0, 8'h00, "R8");
    wr(8'hC4, 8'hFF);
    wr(8'hC0, 8'hEE);
    rd_check(8'hC0, 8'h00, "R8");
    wr(8'hC4, 8'd17);
    rd_check(8'hC0, 8'(17*7 + 3), "R8");

    // R9: reserved offsets
    wr(8'h10, 8'hFF);
    wr(8'hD4, 8'hFF);
    wr(8'hC1, 8'h00);
    rd_check(8'h10, 8'h00, "R9");
    rd_check(8'hD4, 8'h00, "R9");
    rd_check(8'h00, 8'h01, "R9");
    rd_check(8'hC4, 8'd17, "R9");
    rd_check(8'hD0, 8'h3F, "R9");

    // R10: hold, and read-before-write in one cycle
    repeat (4) @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h3F) begin
      errors++; $display("FAIL R10 hold got %02h exp 3f", bus_rdata);
    end
    @(negedge clk);
    bus_addr = 8'hC4; bus_wdata = 8'd2; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== 8'd17) begin
      errors++; $display("FAIL R10 same-cycle got %02h exp 11", bus_rdata);
    end
    rd_check(8'hC4, 8'd2, "R10");

    // R4: disable drops every enable, re-enable restores
    wr(8'h00, 8'h00);
    oe_check('0, "R4");
    wr(8'h00, 8'h01);
    oe_check(18'h3F13F, "R4");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule